// File: doc/BRIEF.md
# Byte-Serial Framed CRC-16 Engine

This block accumulates a 16-bit cyclic redundancy check over a stream of bytes, one byte per clock cycle. The generator polynomial is x^16 + x^15 + x^2 + 1 (0x8005). Each byte is folded into the running state by a parallel XOR network in a single cycle. Frames may have any length, and frames of 128 bytes are typical. A seed/state multiplexer picks the all-ones seed whenever a byte arrives flagged as the start of a frame, so a new frame can begin on the cycle after the previous one ends with no idle cycle between them.

The state register is fed back raw. Bit reversal and complementing are applied only on the way to the output. Each input byte enters the update least-significant bit first, which is the same as reversing the byte and shifting it in most-significant bit first. A byte flagged as the end of a frame makes `crc_valid` pulse for one cycle in the cycle after that byte is taken. In that cycle `crc_out` carries the finished frame CRC.

A small controller tracks the frame with three states:
- `ST_IDLE`: no frame is open.
- `ST_OPEN`: a frame has taken at least one byte and is not yet finished.
- `ST_DONE`: the last byte has just been taken, and `crc_valid` is high.

The transitions are:
- Start/step: IDLE→OPEN, OPEN→OPEN and DONE→OPEN, on an enabled byte without the end flag.
- Finish: any state→DONE, on an enabled byte with the end flag.
- Release: DONE→IDLE, on a cycle with no enabled byte.
- Hold: IDLE→IDLE and OPEN→OPEN, on a cycle with no enabled byte.

Top module: `crc16_frame_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the state is loaded with 0xFFFF and `crc_valid` goes low. After reset, `crc_out` reads 0x0000 and `crc_valid` reads 0.
- R2: The state is updated with polynomial 0x8005 and each byte is taken bit 0 first. `crc_out` is the bitwise complement of the bit-reversed state. Starting from the seed, the bytes 0x01 0x02 0x03 0x04 give 0xD45E, and the ASCII string "123456789" gives 0xB4C8.
- R3: On a cycle where `byte_en` is low, the state is unchanged, so `crc_out` keeps its value on the next cycle.
- R4: When `byte_en` and `sof` are both high, the byte is combined with 0xFFFF instead of the stored state. This holds even in the cycle right after a frame's last byte, and even in the middle of an open frame.
- R5: A byte taken with `eof` high drives `crc_valid` high for exactly the following cycle, unless another enabled `eof` byte follows. In that cycle `crc_out` is the complete frame CRC. `crc_valid` is low after any enabled byte without `eof` and after any cycle with `byte_en` low.
- R6: `sof` and `eof` have no effect while `byte_en` is low: `crc_out` stays unchanged and `crc_valid` stays low.
- R7: A byte with `sof` and `eof` both high forms a one-byte frame whose CRC is presented on the next cycle.
- R8: An enabled byte without `sof` continues from the stored state, even after a finished frame. Bytes sent later therefore extend the previous CRC.
- R9: `crc_out` reflects each enabled byte on the cycle after the edge that takes it, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| byte_in | input | 8 | Data byte |
| byte_en | input | 1 | Byte qualifier; the state advances only when high |
| sof | input | 1 | First byte of a frame; reseeds with 0xFFFF |
| eof | input | 1 | Last byte of a frame |
| crc_out | output | 16 | Complemented, bit-reversed running CRC |
| crc_valid | output | 1 | One-cycle pulse marking a finished frame CRC |

## Verification
Two functions can fall in the same cycle: presenting one frame's finished result and reseeding for the next frame's first byte. With a zero gap between frames, the new `sof` byte is driven during the very cycle that `crc_valid` and the previous CRC are being shown. The bench checks in that cycle that the old result is still correct. On the next cycle it checks that the output equals the CRC of the new byte alone, computed from the seed.

The random runs mix gaps of zero, one and two cycles, and they hold `sof` and `eof` at random levels while `byte_en` is low. Directed cases cover one-byte frames, a restart in the middle of a frame, a frame of 128 bytes and a chained continuation. Every result is compared against a bit-serial model held in the bench.

// File: rtl/crc16_frame_pkg.sv
package crc16_frame_pkg;

    // Frame tracking states of the controller.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_DONE = 2'd2
    } frame_state_t;

endpackage

// File: rtl/crc16_byte_step.sv
// One-cycle parallel update of the CRC state over a whole data word.
module crc16_byte_step #(
    parameter int                 CRC_W  = 16,
    parameter int                 DATA_W = 8,
    parameter logic [CRC_W-1:0]   POLY   = 16'h8005,
    parameter bit                 REFIN  = 1'b1
) (
    input  logic [CRC_W-1:0]  state_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  state_o
);
    localparam int TOP = CRC_W - 1;

    logic [DATA_W-1:0] data_ord;

    // Present bits in the order they are shifted in, MSB of data_ord first.
    generate
        if (REFIN) begin : g_refin
            for (genvar b = 0; b < DATA_W; b++) begin : g_rev
                assign data_ord[b] = data_i[DATA_W-1-b];
            end
        end else begin : g_norm
            assign data_ord = data_i;
        end
    endgenerate

    // Unrolled shift network; collapses to a flat XOR tree per bit.
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = state_i;
        for (int i = 0; i < DATA_W; i++) begin
            fb  = acc[TOP] ^ data_ord[DATA_W-1-i];
            acc = {acc[TOP-1:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        state_o = acc;
    end
endmodule

// File: rtl/crc16_seed_mux.sv
// Picks either the seed or the stored state as the update input.
module crc16_seed_mux #(
    parameter int               CRC_W = 16,
    parameter logic [CRC_W-1:0] SEED  = 16'hFFFF
) (
    input  logic             restart_i,
    input  logic [CRC_W-1:0] stored_i,
    output logic [CRC_W-1:0] base_o
);
    always_comb begin
        if (restart_i) begin
            base_o = SEED;
        end else begin
            base_o = stored_i;
        end
    end
endmodule

// File: rtl/crc16_out_map.sv
// Output path: optional bit reversal followed by a final XOR.
module crc16_out_map #(
    parameter int               CRC_W  = 16,
    parameter bit               REFOUT = 1'b1,
    parameter logic [CRC_W-1:0] XOROUT = 16'hFFFF
) (
    input  logic [CRC_W-1:0] state_i,
    output logic [CRC_W-1:0] crc_o
);
    logic [CRC_W-1:0] ordered;

    generate
        if (REFOUT) begin : g_refout
            for (genvar b = 0; b < CRC_W; b++) begin : g_rev
                assign ordered[b] = state_i[CRC_W-1-b];
            end
        end else begin : g_norm
            assign ordered = state_i;
        end
    endgenerate

    assign crc_o = ordered ^ XOROUT;
endmodule

// File: rtl/crc16_frame_ctrl.sv
// Frame controller: decides reseed, load and the result pulse.
module crc16_frame_ctrl
    import crc16_frame_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic sof_i,
    input  logic eof_i,
    output logic load_o,
    output logic restart_o,
    output logic valid_o
);
    frame_state_t state_q;
    frame_state_t state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i) begin
                    state_d = eof_i ? ST_DONE : ST_OPEN;   // start/step or finish
                end
            end
            ST_OPEN: begin
                if (en_i && eof_i) begin
                    state_d = ST_DONE;                     // finish
                end
            end
            ST_DONE: begin
                if (en_i) begin
                    state_d = eof_i ? ST_DONE : ST_OPEN;   // back-to-back frame
                end else begin
                    state_d = ST_IDLE;                     // release
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        load_o    = en_i;
        restart_o = en_i && sof_i;
        valid_o   = (state_q == ST_DONE);
    end

    // R5: a result pulse is always caused by an enabled end-of-frame byte.
    p_valid_src_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(en_i && eof_i));

    // R5: with no enabled byte, the pulse lasts one cycle.
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !en_i) |=> !valid_o);

    // R4: a start byte without the end flag leaves a frame open.
    p_open_r4: assert property (@(posedge clk) disable iff (rst)
        (en_i && sof_i && !eof_i) |=> (state_q == ST_OPEN));

    // R6: a cycle with no enabled byte never raises the pulse.
    p_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !valid_o) |=> !valid_o);
endmodule

// File: rtl/crc16_frame_engine.sv
// Top: byte-serial framed CRC-16 engine.
module crc16_frame_engine #(
    parameter int               CRC_W  = 16,
    parameter int               DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY   = 16'h8005,
    parameter logic [CRC_W-1:0] SEED   = 16'hFFFF,
    parameter logic [CRC_W-1:0] XOROUT = 16'hFFFF,
    parameter bit               REFIN  = 1'b1,
    parameter bit               REFOUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              byte_en,
    input  logic              sof,
    input  logic              eof,
    output logic [CRC_W-1:0]  crc_out,
    output logic              crc_valid
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] next_state;
    logic             load;
    logic             restart;

    crc16_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en_i      (byte_en),
        .sof_i     (sof),
        .eof_i     (eof),
        .load_o    (load),
        .restart_o (restart),
        .valid_o   (crc_valid)
    );

    crc16_seed_mux #(.CRC_W(CRC_W), .SEED(SEED)) u_mux (
        .restart_i (restart),
        .stored_i  (crc_q),
        .base_o    (base)
    );

    crc16_byte_step #(
        .CRC_W (CRC_W), .DATA_W(DATA_W), .POLY(POLY), .REFIN(REFIN)
    ) u_step (
        .state_i (base),
        .data_i  (byte_in),
        .state_o (next_state)
    );

    // Raw state register; no reversal or inversion in the feedback loop.
    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= SEED;
        end else if (load) begin
            crc_q <= next_state;
        end
    end

    crc16_out_map #(.CRC_W(CRC_W), .REFOUT(REFOUT), .XOROUT(XOROUT)) u_out (
        .state_i (crc_q),
        .crc_o   (crc_out)
    );

    // R1: leaving reset, the state holds the seed and no pulse is shown.
    p_reset_seed_r1: assert property (@(posedge clk)
        $fell(rst) |-> (crc_q == SEED && !crc_valid));

    // R3: with no enabled byte, the state and the output are frozen.
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !byte_en |=> ($stable(crc_q) && $stable(crc_out)));
endmodule

// File: tb/crc16_frame_engine_tb.sv
`timescale 1ns/1ps
module crc16_frame_engine_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  byte_in;
    logic        byte_en;
    logic        sof;
    logic        eof;
    logic [15:0] crc_out;
    logic        crc_valid;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] ref_state;
    logic [15:0] prev_out;

    always #2.5 clk = ~clk;

    crc16_frame_engine u_dut (
        .clk(clk), .rst(rst), .byte_in(byte_in), .byte_en(byte_en),
        .sof(sof), .eof(eof), .crc_out(crc_out), .crc_valid(crc_valid)
    );

    // Bit-serial model: LSB of each byte first, polynomial 0x8005.
    function automatic logic [15:0] ref_step(logic [15:0] c, logic [7:0] b);
        logic fb;
        for (int i = 0; i < 8; i++) begin
            fb = c[15] ^ b[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h8005;
        end
        return c;
    endfunction

    function automatic logic [15:0] ref_out(logic [15:0] c);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = c[15-i];
        return ~r;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic drive(input logic en, input logic s, input logic e, input logic [7:0] b,
                         input string req);
        byte_en = en; sof = s; eof = e; byte_in = b;
        @(negedge clk);
        if (en) begin
            if (s) ref_state = 16'hFFFF;
            ref_state = ref_step(ref_state, b);
            check({req, "/R9 crc after byte"}, crc_out, ref_out(ref_state));
            check({req, "/R5 valid after byte"}, {15'd0, crc_valid}, {15'd0, e});
        end else begin
            check({req, "/R3 R6 crc held"}, crc_out, prev_out);
            check({req, "/R6 valid low in gap"}, {15'd0, crc_valid}, 16'd0);
        end
        prev_out = crc_out;
    endtask

    task automatic idle_gap(input int n, input string req);
        for (int k = 0; k < n; k++)
            drive(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  8'($urandom), req);
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        logic [7:0] str [9];
        void'($urandom(32'd2024));
        rst = 1'b1; byte_en = 1'b0; sof = 1'b0; eof = 1'b0; byte_in = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 crc after reset", crc_out, 16'h0000);
        check("R1 valid after reset", {15'd0, crc_valid}, 16'd0);
        ref_state = 16'hFFFF;
        prev_out = crc_out;

        // R2: known vector 01 02 03 04
        drive(1'b1, 1'b1, 1'b0, 8'h01, "R2");
        drive(1'b1, 1'b0, 1'b0, 8'h02, "R2");
        drive(1'b1, 1'b0, 1'b0, 8'h03, "R2");
        drive(1'b1, 1'b0, 1'b1, 8'h04, "R2");
        check("R2 vector 01..04", crc_out, 16'hD45E);
        check("R5 valid on last byte", {15'd0, crc_valid}, 16'd1);

        // R2 and R4: "123456789" sent back-to-back after the previous frame
        str = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        for (int i = 0; i < 9; i++)
            drive(1'b1, i == 0, i == 8, str[i], "R4 back-to-back");
        check("R2 check string", crc_out, 16'hB4C8);
        idle_gap(3, "R6");

        // R7: one-byte frames, back-to-back
        drive(1'b1, 1'b1, 1'b1, 8'hA5, "R7");
        drive(1'b1, 1'b1, 1'b1, 8'h3C, "R7");
        check("R7 single byte crc", crc_out, ref_out(ref_step(16'hFFFF, 8'h3C)));
        idle_gap(1, "R5 release");

        // R4: restart in the middle of an open frame
        drive(1'b1, 1'b1, 1'b0, 8'h11, "R4 mid");
        drive(1'b1, 1'b0, 1'b0, 8'h22, "R4 mid");
        drive(1'b1, 1'b1, 1'b0, 8'h33, "R4 mid");
        drive(1'b1, 1'b0, 1'b1, 8'h44, "R4 mid");
        check("R4 restart result",
              crc_out, ref_out(ref_step(ref_step(16'hFFFF, 8'h33), 8'h44)));

        // R8: chained continuation without sof
        idle_gap(2, "R8");
        drive(1'b1, 1'b0, 1'b0, 8'h55, "R8 chain");
        drive(1'b1, 1'b0, 1'b1, 8'h66, "R8 chain");

        // 128-byte frame with holes
        for (int i = 0; i < 128; i++) begin
            if ($urandom_range(0, 7) == 0) idle_gap(1, "R3 hole");
            drive(1'b1, i == 0, i == 127, 8'($urandom), "R2 long frame");
        end

        // Random frames, random lengths, gaps of 0..2 cycles
        for (int f = 0; f < 80; f++) begin
            int len;
            len = $urandom_range(1, 40);
            for (int i = 0; i < len; i++) begin
                if ($urandom_range(0, 9) == 0) idle_gap(1, "R3 hole");
                drive(1'b1, i == 0, i == len - 1, 8'($urandom), "R4 random frame");
            end
            idle_gap($urandom_range(0, 2), "R6 random gap");
        end

        summary_and_end();
    end
endmodule